// File: doc/BRIEF.md
# SYSREF Divider and Pulse Generator

This block runs from one high-rate VCO clock. It divides that clock down into a small bank of device clocks and one SYSREF clock, each with its own integer ratio. Software realigns the dividers by driving a polarity bit from 0 to 1. On that rising edge, every divider that takes part restarts in the same VCO cycle. The device clocks and SYSREF therefore keep a fixed phase relationship, and each divider can push its first rising edge later by a programmed number of VCO cycles.

The SYSREF divider output passes through a pulser before it leaves the block. A rising edge on a request input arms either a counted burst or a continuous stream of pulses. The pulser only ever passes whole SYSREF periods. A local delay stage guards the SYSREF path. After reset, and after each SYSREF power-down, this stage must be held in clear for a minimum run of VCO cycles and then released before any SYSREF pulse can appear.

Top module: `sysref_clkgen`

## Requirements
- R1: With a ratio R of 2 or more, a divider output repeats every R VCO cycles and is high for floor(R/2) of them. An odd ratio therefore has a high phase one cycle shorter than its low phase.
- R2: A ratio of 0 or 1 passes the VCO clock straight through to the device-clock output.
- R3: A rising edge of `sync_pol`, sampled on a VCO edge, restarts every participating divider on that edge with its output low. With zero delay, all participating outputs go high together on the next edge.
- R4: A divider whose sync-disable bit is 1 ignores a realignment and keeps its free-running phase.
- R5: A realignment has effect only when `sync_en` is 1 and both `sysref_pd` and `ddly_pd` are 0. Otherwise no divider changes phase.
- R6: A delay value D holds a restarted divider low for D extra cycles. Its first high therefore comes D+1 edges after the realigning edge.
- R7: SYSREF stays low after reset and after any `sysref_pd` assertion until `ddly_clr` has been sampled high on at least 15 consecutive edges and then released. A shorter clear leaves SYSREF disabled.
- R8: When `pulse_cont` is 0, a rising edge of `pulse_req` emits exactly `pulse_cnt`+1 complete SYSREF pulses, each floor(R/2) cycles wide. SYSREF then stays low.
- R9: When `pulse_cont` is 1, a request starts an unbounded pulse stream. Clearing `pulse_cont` stops the stream at the end of a pulse.
- R10: While `sysref_pd` or `ddly_clr` is held high, SYSREF is low from the next edge on, and a running stream is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_pol | input | 1 | Realignment trigger; its rising edge realigns the dividers |
| sync_en | input | 1 | Allows realignment |
| sysref_pd | input | 1 | SYSREF power-down |
| ddly_pd | input | 1 | Digital delay power-down |
| sync_dis | input | NUM_DCLK | Per-device-clock exclusion from realignment |
| sync_dis_sr | input | 1 | SYSREF divider exclusion from realignment |
| dclk_ratio | input | NUM_DCLK*DIV_W | Device-clock ratios, divider i in bits [i*DIV_W +: DIV_W] |
| dclk_dly | input | NUM_DCLK*DLY_W | Device-clock start delays, divider i in bits [i*DLY_W +: DLY_W] |
| sr_ratio | input | DIV_W | SYSREF divider ratio, 2 or more |
| sr_dly | input | DLY_W | SYSREF divider start delay |
| ddly_clr | input | 1 | Local delay clear |
| pulse_cnt | input | PCNT_W | Burst length minus one |
| pulse_cont | input | 1 | Continuous pulse mode |
| pulse_req | input | 1 | Burst request, rising-edge sensitive |
| dclk_out | output | NUM_DCLK | Device clocks |
| sysref_out | output | 1 | Gated SYSREF |

## Verification
The bench walks a table of ratios and delays through a realignment, covering odd ratios, a ratio of 20 and non-zero delays. A wrong duty split or an off-by-one in the delay hold shows up as a shifted or stretched high phase. The exclusion and enable gating are checked against each divider's own phase one period earlier: a divider that wrongly obeys a blocked realignment breaks that periodicity. On the SYSREF side the bench tries a clear one cycle too short and burst lengths of 1, 2, 4 and 8. It also stops continuous mode, then drops the stream with a clear and with a power-down. A counter off by one would give the wrong pulse count, a gate that forgets to re-arm would emit pulses after power-down, and careless gating would produce runt pulses.

// File: rtl/sysref_pkg.sv
package sysref_pkg;

    localparam int DIV_W  = 10;
    localparam int DLY_W  = 4;
    localparam int PCNT_W = 3;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_ARM,
        PS_BURST,
        PS_CONT
    } pulse_st_e;

    typedef struct packed {
        logic [DIV_W-1:0] ratio;
        logic [DLY_W-1:0] dly;
        logic             sync_ok;
    } div_cfg_t;

    function automatic logic [DIV_W-1:0] eff_ratio(input logic [DIV_W-1:0] r);
        return (r <= DIV_W'(1)) ? DIV_W'(1) : r;
    endfunction

    function automatic logic is_bypass(input logic [DIV_W-1:0] r);
        return (r <= DIV_W'(1));
    endfunction

endpackage

// File: rtl/sr_clk_div.sv
module sr_clk_div
    import sysref_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t cfg,
    input  logic     sync_go,
    output logic     q,
    output logic     clk_out
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] hi_len;
    logic [DLY_W-1:0] hold;
    logic             byp;

    always_comb begin
        eff    = eff_ratio(cfg.ratio);
        hi_len = eff >> 1;
        byp    = is_bypass(cfg.ratio);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            hold <= '0;
            q    <= 1'b0;
        end else if (sync_go && cfg.sync_ok) begin
            cnt  <= '0;
            hold <= cfg.dly;
            q    <= 1'b0;
        end else if (hold != '0) begin
            hold <= hold - DLY_W'(1);
            q    <= 1'b0;
        end else begin
            q   <= (cnt < hi_len);
            cnt <= (cnt >= eff - DIV_W'(1)) ? '0 : cnt + DIV_W'(1);
        end
    end

    assign clk_out = byp ? clk : q;

endmodule

// File: rtl/sr_ddly_gate.sv
module sr_ddly_gate #(
    parameter int CLR_MIN = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic pd,
    input  logic clr,
    output logic ok
);

    localparam int CW = $clog2(CLR_MIN + 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            run <= '0;
            ok  <= 1'b0;
        end else if (clr) begin
            ok <= 1'b0;
            if (run != CW'(CLR_MIN)) begin
                run <= run + CW'(1);
            end
        end else begin
            if (run == CW'(CLR_MIN)) begin
                ok <= 1'b1;
            end
            run <= '0;
        end
    end

endmodule

// File: rtl/sr_pulser.sv
module sr_pulser
    import sysref_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dly_ok,
    input  logic              div_q,
    input  logic              req,
    input  logic              cont,
    input  logic [PCNT_W-1:0] cnt,
    output logic              sr_out
);

    localparam int RW = PCNT_W + 1;

    pulse_st_e      st;
    logic           cont_mode;
    logic [RW-1:0]  rem;
    logic           req_q;
    logic           q_d;
    logic           req_rise;
    logic           q_fall;

    assign req_rise = req & ~req_q;
    assign q_fall   = q_d & ~div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PS_IDLE;
            cont_mode <= 1'b0;
            rem       <= '0;
            req_q     <= 1'b0;
            q_d       <= 1'b0;
        end else begin
            req_q <= req;
            q_d   <= div_q;
            if (!dly_ok) begin
                st <= PS_IDLE;
            end else begin
                unique case (st)
                    PS_IDLE: begin
                        if (req_rise) begin
                            st        <= PS_ARM;
                            cont_mode <= cont;
                            rem       <= RW'(cnt) + RW'(1);
                        end
                    end
                    PS_ARM: begin
                        if (!div_q) begin
                            st <= cont_mode ? PS_CONT : PS_BURST;
                        end
                    end
                    PS_BURST: begin
                        if (q_fall) begin
                            rem <= rem - RW'(1);
                            if (rem == RW'(1)) begin
                                st <= PS_IDLE;
                            end
                        end
                    end
                    PS_CONT: begin
                        if (!cont && !div_q) begin
                            st <= PS_IDLE;
                        end
                    end
                    default: st <= PS_IDLE;
                endcase
            end
        end
    end

    assign sr_out = ((st == PS_BURST) || (st == PS_CONT)) && dly_ok && div_q;

endmodule

// File: rtl/sysref_clkgen.sv
module sysref_clkgen
    import sysref_pkg::*;
#(
    parameter int NUM_DCLK = 3,
    parameter int CLR_MIN  = 15
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sync_pol,
    input  logic                      sync_en,
    input  logic                      sysref_pd,
    input  logic                      ddly_pd,
    input  logic [NUM_DCLK-1:0]       sync_dis,
    input  logic                      sync_dis_sr,
    input  logic [NUM_DCLK*DIV_W-1:0] dclk_ratio,
    input  logic [NUM_DCLK*DLY_W-1:0] dclk_dly,
    input  logic [DIV_W-1:0]          sr_ratio,
    input  logic [DLY_W-1:0]          sr_dly,
    input  logic                      ddly_clr,
    input  logic [PCNT_W-1:0]         pulse_cnt,
    input  logic                      pulse_cont,
    input  logic                      pulse_req,
    output logic [NUM_DCLK-1:0]       dclk_out,
    output logic                      sysref_out
);

    localparam int NDIV = NUM_DCLK + 1;

    logic     sync_q;
    logic     sync_go;
    logic     dly_ok;
    logic     sr_q;
    div_cfg_t cfg_a [NDIV];
    logic     q_a   [NDIV];
    logic     co_a  [NDIV];

    always_ff @(posedge clk) begin
        sync_q <= rst ? 1'b0 : sync_pol;
    end

    assign sync_go = sync_pol & ~sync_q & sync_en & ~sysref_pd & ~ddly_pd;

    genvar i;
    generate
        for (i = 0; i < NDIV; i++) begin : g_div
            if (i < NUM_DCLK) begin : g_dclk
                assign cfg_a[i].ratio   = dclk_ratio[i*DIV_W +: DIV_W];
                assign cfg_a[i].dly     = dclk_dly[i*DLY_W +: DLY_W];
                assign cfg_a[i].sync_ok = ~sync_dis[i];
                assign dclk_out[i]      = co_a[i];
            end else begin : g_sr
                assign cfg_a[i].ratio   = sr_ratio;
                assign cfg_a[i].dly     = sr_dly;
                assign cfg_a[i].sync_ok = ~sync_dis_sr;
                assign sr_q             = q_a[i];
            end

            sr_clk_div u_div (
                .clk     (clk),
                .rst     (rst),
                .cfg     (cfg_a[i]),
                .sync_go (sync_go),
                .q       (q_a[i]),
                .clk_out (co_a[i])
            );
        end
    endgenerate

    sr_ddly_gate #(.CLR_MIN(CLR_MIN)) u_gate (
        .clk (clk),
        .rst (rst),
        .pd  (sysref_pd),
        .clr (ddly_clr),
        .ok  (dly_ok)
    );

    sr_pulser u_pulser (
        .clk    (clk),
        .rst    (rst),
        .dly_ok (dly_ok),
        .div_q  (sr_q),
        .req    (pulse_req),
        .cont   (pulse_cont),
        .cnt    (pulse_cnt),
        .sr_out (sysref_out)
    );

endmodule

// File: rtl/sysref_clkgen_chk.sv
module sysref_clkgen_chk
    import sysref_pkg::*;
#(
    parameter int NUM_DCLK = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      sync_pol,
    input logic                      sync_en,
    input logic                      sysref_pd,
    input logic                      ddly_pd,
    input logic [NUM_DCLK-1:0]       sync_dis,
    input logic                      sync_dis_sr,
    input logic [NUM_DCLK*DIV_W-1:0] dclk_ratio,
    input logic [DIV_W-1:0]          sr_ratio,
    input logic                      ddly_clr,
    input logic [NUM_DCLK-1:0]       dclk_out,
    input logic                      sysref_out
);

    genvar i;
    generate
        for (i = 0; i < NUM_DCLK; i++) begin : g_chk
            AST_SYNC_DCLK_LOW: assert property (@(posedge clk) disable iff (rst)
                ($rose(sync_pol) && sync_en && !sysref_pd && !ddly_pd && !sync_dis[i]
                 && (dclk_ratio[i*DIV_W +: DIV_W] > DIV_W'(1))) |=> !dclk_out[i]); // R3
        end
    endgenerate

    AST_SYNC_SR_LOW: assert property (@(posedge clk) disable iff (rst)
        ($rose(sync_pol) && sync_en && !sysref_pd && !ddly_pd && !sync_dis_sr
         && (sr_ratio > DIV_W'(1))) |=> !sysref_out); // R3

    AST_PD_SR_LOW: assert property (@(posedge clk) disable iff (rst)
        (sysref_pd && $past(sysref_pd)) |-> !sysref_out); // R10

    AST_CLR_SR_LOW: assert property (@(posedge clk) disable iff (rst)
        (ddly_clr && $past(ddly_clr)) |-> !sysref_out); // R10

endmodule

bind sysref_clkgen sysref_clkgen_chk #(.NUM_DCLK(NUM_DCLK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_pol    (sync_pol),
    .sync_en     (sync_en),
    .sysref_pd   (sysref_pd),
    .ddly_pd     (ddly_pd),
    .sync_dis    (sync_dis),
    .sync_dis_sr (sync_dis_sr),
    .dclk_ratio  (dclk_ratio),
    .sr_ratio    (sr_ratio),
    .ddly_clr    (ddly_clr),
    .dclk_out    (dclk_out),
    .sysref_out  (sysref_out)
);

// File: tb/tb_sysref_clkgen.sv
module tb_sysref_clkgen;
    import sysref_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ND = 3;
    localparam int NV = 6;
    localparam int VR [NV] = '{2, 3, 20, 5, 4, 7};
    localparam int VD [NV] = '{0, 0, 0, 3, 1, 2};
    localparam int VH [NV] = '{1, 1, 10, 2, 2, 3};

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                sync_pol = 1'b0;
    logic                sync_en = 1'b1;
    logic                sysref_pd = 1'b0;
    logic                ddly_pd = 1'b0;
    logic [ND-1:0]       sync_dis = '0;
    logic                sync_dis_sr = 1'b0;
    logic [ND*DIV_W-1:0] dclk_ratio;
    logic [ND*DLY_W-1:0] dclk_dly = '0;
    logic [DIV_W-1:0]    sr_ratio = DIV_W'(6);
    logic [DLY_W-1:0]    sr_dly = '0;
    logic                ddly_clr = 1'b0;
    logic [PCNT_W-1:0]   pulse_cnt = '0;
    logic                pulse_cont = 1'b0;
    logic                pulse_req = 1'b0;
    logic [ND-1:0]       dclk_out;
    logic                sysref_out;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysref_clkgen #(.NUM_DCLK(ND), .CLR_MIN(15)) dut (
        .clk(clk), .rst(rst), .sync_pol(sync_pol), .sync_en(sync_en),
        .sysref_pd(sysref_pd), .ddly_pd(ddly_pd), .sync_dis(sync_dis),
        .sync_dis_sr(sync_dis_sr), .dclk_ratio(dclk_ratio), .dclk_dly(dclk_dly),
        .sr_ratio(sr_ratio), .sr_dly(sr_dly), .ddly_clr(ddly_clr),
        .pulse_cnt(pulse_cnt), .pulse_cont(pulse_cont), .pulse_req(pulse_req),
        .dclk_out(dclk_out), .sysref_out(sysref_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_ratio(input int idx, input int r, input int d);
        dclk_ratio[idx*DIV_W +: DIV_W] = DIV_W'(r);
        dclk_dly[idx*DLY_W +: DLY_W]   = DLY_W'(d);
    endtask

    // called at a negedge; returns at the negedge after the realigning edge
    task automatic fire_sync();
        sync_pol = 1'b1;
        @(negedge clk);
        sync_pol = 1'b0;
    endtask

    // divider 1 runs at ratio 20; a blocked realignment keeps its period
    task automatic periodic_check(input string req);
        logic hist [20];
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            hist[i] = dclk_out[1];
        end
        fire_sync();
        for (int j = 20; j < 40; j++) begin
            if (j > 20) @(negedge clk);
            chk(req, int'(dclk_out[1]), int'(hist[j-20]));
        end
    endtask

    task automatic hold_clear(input int n);
        ddly_clr = 1'b1;
        repeat (n) @(negedge clk);
        ddly_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic watch_sr(input logic do_req, input int ncyc,
                            output int np, output int bad_w);
        logic prev = sysref_out;
        int   run = 0;
        np = 0;
        bad_w = 0;
        if (do_req) pulse_req = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            pulse_req = 1'b0;
            if (sysref_out && !prev) begin
                np++;
                run = 0;
            end
            if (sysref_out) run++;
            if (!sysref_out && prev && run != 3) bad_w++;
            prev = sysref_out;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int np;
        int bw;
        set_ratio(0, 2, 0);
        set_ratio(1, 20, 0);
        set_ratio(2, 3, 0);
        repeat (4) @(negedge clk);
        // reset state: registered dividers low, SYSREF low (R1, R7)
        chk("R1 reset dclk", int'(dclk_out), 0);
        chk("R7 reset sysref", int'(sysref_out), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // table walk: ratio / delay / expected high length on divider 0 (R1, R3, R6)
        for (int v = 0; v < NV; v++) begin
            set_ratio(0, VR[v], VD[v]);
            @(negedge clk);
            fire_sync();
            chk("R3 restart low", int'(dclk_out[0]), 0);
            for (int j = 1; j <= VD[v] + 2*VR[v]; j++) begin
                @(negedge clk);
                if (j <= VD[v])
                    chk("R6 delay hold", int'(dclk_out[0]), 0);
                else
                    chk("R1 duty", int'(dclk_out[0]),
                        int'(((j - 1 - VD[v]) % VR[v]) < VH[v]));
            end
        end

        // alignment of all device clocks (R3)
        set_ratio(0, 2, 0);
        @(negedge clk);
        fire_sync();
        chk("R3 aligned low", int'(dclk_out), 0);
        @(negedge clk);
        chk("R3 aligned rise", int'(dclk_out), 7);

        // exclusion (R4)
        sync_dis = 3'b010;
        periodic_check("R4 excluded divider");
        sync_dis = '0;

        // enable gating (R5)
        sync_en = 1'b0;
        periodic_check("R5 sync_en low");
        sync_en = 1'b1;
        sysref_pd = 1'b1;
        periodic_check("R5 sysref_pd high");
        sysref_pd = 1'b0;
        ddly_pd = 1'b1;
        periodic_check("R5 ddly_pd high");
        ddly_pd = 1'b0;

        // bypass ratios (R2)
        for (int r = 0; r < 2; r++) begin
            set_ratio(2, r, 0);
            @(posedge clk);
            #1 chk("R2 bypass high", int'(dclk_out[2]), 1);
            @(negedge clk);
            #1 chk("R2 bypass low", int'(dclk_out[2]), 0);
        end
        set_ratio(2, 3, 0);

        // short clear leaves SYSREF off (R7)
        @(negedge clk);
        pulse_cnt = 3'd1;
        hold_clear(14);
        watch_sr(1'b1, 60, np, bw);
        chk("R7 short clear", np, 0);

        // full clear, bursts of several lengths (R7, R8)
        hold_clear(15);
        watch_sr(1'b1, 80, np, bw);
        chk("R7 R8 burst of 2", np, 2);
        chk("R8 width", bw, 0);
        pulse_cnt = 3'd3;
        watch_sr(1'b1, 100, np, bw);
        chk("R8 burst of 4", np, 4);
        pulse_cnt = 3'd0;
        watch_sr(1'b1, 60, np, bw);
        chk("R8 burst of 1", np, 1);
        pulse_cnt = 3'd7;
        watch_sr(1'b1, 140, np, bw);
        chk("R8 burst of 8", np, 8);
        chk("R8 width 8", bw, 0);

        // continuous mode (R9)
        pulse_cont = 1'b1;
        watch_sr(1'b1, 60, np, bw);
        chk("R9 stream", int'(np >= 8), 1);
        chk("R9 width", bw, 0);
        pulse_cont = 1'b0;
        repeat (12) @(negedge clk);
        watch_sr(1'b0, 40, np, bw);
        chk("R9 stopped", np, 0);

        // clear held during a stream (R10)
        pulse_cont = 1'b1;
        watch_sr(1'b1, 30, np, bw);
        ddly_clr = 1'b1;
        watch_sr(1'b0, 20, np, bw);
        chk("R10 clear kills", np, 0);
        ddly_clr = 1'b0;
        @(negedge clk);

        // power-down during a stream (R10), then re-clear required (R7)
        watch_sr(1'b1, 30, np, bw);
        chk("R9 restream", int'(np >= 3), 1);
        sysref_pd = 1'b1;
        watch_sr(1'b0, 30, np, bw);
        chk("R10 pd kills", np, 0);
        sysref_pd = 1'b0;
        pulse_cont = 1'b0;
        @(negedge clk);
        watch_sr(1'b1, 40, np, bw);
        chk("R7 pd needs clear", np, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule